// File: doc/BRIEF.md
# Receive Ring Buffer Writer

This block sits behind an Ethernet receive MAC and turns its byte stream into a sequence of records in a circular byte memory. Each byte of a frame is stored as it arrives. When the frame ends, the block decides whether to keep it. If kept, the block writes a 4-byte header in front of the stored data, and only then moves its write offset past the record. A host walks the ring through a read port. It tells the block how far it has consumed by writing a read-pointer register. It polls a buffer-empty flag to learn whether unread records remain.

A frame is kept only if two things hold. Its destination class must be enabled in a set of accept flags. Its error and runt conditions must also be enabled. A kept frame that would not fit in the free space is discarded and reported through an interrupt bit. A frame that starts while a header is still being written is also discarded, and reported through a separate interrupt bit. Records start on 4-byte boundaries and may wrap past the end of the ring back to offset 0. The ring size is chosen at run time as one, two or four times a base size.

Top module: `rx_ring_writer`

## Requirements
- R1: The ring holds BASE_BYTES << s bytes, where s is `cfg_size_sel`; a value of 3 acts as 2. Every memory offset the block uses is taken modulo the current ring size.
- R2: A kept frame of L bytes (L counts every byte received, FCS included) forms a record at the write offset W. Byte W holds status[7:0], byte W+1 holds status[15:8], byte W+2 holds L[7:0] and byte W+3 holds L[15:8]. Frame byte i is stored at W+4+i.
- R3: The status word uses these bits: bit 0 frame good, bit 1 alignment error, bit 2 CRC error, bit 3 longer than MAX_LEN, bit 4 shorter than MIN_LEN, bit 5 symbol error, bit 13 broadcast destination, bit 14 destination equals `station_addr`, bit 15 group destination other than broadcast. Bit 0 is 1 exactly when bits 1 to 5 are all 0.
- R4: After a record is kept, the write offset becomes W + ((L + 7) with the low two bits cleared), modulo the ring size. It is always a multiple of 4.
- R5: The host read offset is the value last written through `hp_we` plus 16, modulo the ring size. After reset the register holds 16'hFFF0, so the host read offset is 0.
- R6: `buf_empty` is 1 exactly when the host read offset equals the write offset. It is 1 after reset.
- R7: The accept flags in `cfg_accept` work as follows. Bit 3 admits broadcast frames. Bit 2 admits other group frames. Bit 1 admits unicast frames addressed to `station_addr`. Bit 0 admits every unicast frame. A frame whose class is not admitted leaves no record and raises no interrupt.
- R8: A frame with any of the status bits 1, 2, 3 or 5 is kept only when `cfg_accept` bit 5 is 1. A frame shorter than MIN_LEN is kept only when `cfg_accept` bit 4 is 1.
- R9: An otherwise kept frame is dropped when used bytes + record size + 4 exceeds the ring size. When that happens, `int_status` bit 4 is set and no stored record changes.
- R10: `int_status` bit 0 is set when a record whose status bit 0 is 1 becomes visible.
- R11: If a stream byte arrives while a header is being written, `int_status` bit 6 is set. The frame that byte belongs to is discarded whole. The next frame that starts with the block idle is handled normally.
- R12: `int_status` bits are cleared by a write with `int_clr_we`; each 1 in `int_clr_data` clears its bit. Unused bits read 0.
- R13: A record that runs past the last ring byte continues at offset 0.
- R14: `host_rdata` shows the byte at `host_raddr` one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_size_sel | input | 2 | Ring size selector |
| cfg_accept | input | 6 | Accept flags |
| station_addr | input | 48 | Own address; bits 47:40 are the first byte on the wire |
| rx_valid | input | 1 | Stream byte valid |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_data | input | 8 | Stream byte |
| rx_err_align | input | 1 | Alignment error, sampled with the last byte |
| rx_err_crc | input | 1 | CRC error, sampled with the last byte |
| rx_err_symbol | input | 1 | Symbol error, sampled with the last byte |
| hp_we | input | 1 | Write strobe for the host pointer register |
| hp_wdata | input | 16 | Host read offset minus 16 |
| int_clr_we | input | 1 | Interrupt clear strobe |
| int_clr_data | input | 16 | Interrupt bits to clear |
| int_status | output | 16 | Interrupt status (bits 0, 4, 6) |
| buf_empty | output | 1 | No unread record remains |
| host_raddr | input | OFF_W | Host read address into the ring |
| host_rdata | output | 8 | Byte at the host read address |

## Verification
The last byte of a frame is taken at clock edge E. A drop decision, and with it interrupt bit 4, shows at E+1. The four header writes take edges E+1 to E+4. The write offset, `buf_empty` and interrupt bit 0 change at E+4. The bench therefore waits six full cycles after the last byte before it looks at any of these results. Host pointer and interrupt clear writes take effect at the next edge, and memory reads return one edge after the address is set. The bench presents each address or write on a falling edge and samples on the following falling edge.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    localparam int INT_RX_OK    = 0;
    localparam int INT_RING_OVF = 4;
    localparam int INT_FIFO_OVF = 6;

    localparam int ACC_ALL_UNI = 0;
    localparam int ACC_OWN     = 1;
    localparam int ACC_GROUP   = 2;
    localparam int ACC_BCAST   = 3;
    localparam int ACC_RUNT    = 4;
    localparam int ACC_ERR     = 5;

    typedef struct packed {
        logic       grp;
        logic       phys;
        logic       bcast;
        logic [6:0] rsvd;
        logic       bad_sym;
        logic       runt;
        logic       too_long;
        logic       crc;
        logic       align;
        logic       ok;
    } rec_status_t;

    typedef struct packed {
        logic bcast;
        logic group;
        logic own;
    } dest_cls_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RECV = 2'd1,
        ST_DROP = 2'd2,
        ST_HDR  = 2'd3
    } wr_state_e;

    // header plus frame, rounded up to a 4-byte multiple
    function automatic logic [17:0] rec_span(input logic [15:0] len);
        logic [17:0] raw;
        raw = 18'(len) + 18'd7;
        return {raw[17:2], 2'b00};
    endfunction

    function automatic logic [7:0] station_byte(input logic [47:0] sa,
                                                input logic [2:0]  idx);
        case (idx)
            3'd0:    return sa[47:40];
            3'd1:    return sa[39:32];
            3'd2:    return sa[31:24];
            3'd3:    return sa[23:16];
            3'd4:    return sa[15:8];
            default: return sa[7:0];
        endcase
    endfunction

    function automatic logic [7:0] hdr_byte(input rec_status_t st,
                                            input logic [15:0] len,
                                            input logic [1:0]  idx);
        logic [15:0] s;
        s = st;
        case (idx)
            2'd0:    return s[7:0];
            2'd1:    return s[15:8];
            2'd2:    return len[7:0];
            default: return len[15:8];
        endcase
    endfunction

endpackage

// File: rtl/rxr_dest_filter.sv
module rxr_dest_filter
    import rxr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        take,
    input  logic [15:0] byte_idx,
    input  logic [7:0]  data,
    input  logic [47:0] station,
    output dest_cls_t   cls_next
);

    dest_cls_t cls_q;
    logic      cur_ff;
    logic      cur_own;

    always_comb begin
        cur_ff  = (data == 8'hFF);
        cur_own = (data == station_byte(station, byte_idx[2:0]));
        if (byte_idx == 16'd0) begin
            cls_next.bcast = cur_ff;
            cls_next.own   = cur_own;
            cls_next.group = data[0];
        end else if (byte_idx < 16'd6) begin
            cls_next.bcast = cls_q.bcast & cur_ff;
            cls_next.own   = cls_q.own & cur_own;
            cls_next.group = cls_q.group;
        end else begin
            cls_next = cls_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cls_q <= '0;
        end else if (take) begin
            cls_q <= cls_next;
        end
    end

endmodule

// File: rtl/rxr_space.sv
module rxr_space #(
    parameter int OFF_W = 10
) (
    input  logic [OFF_W-1:0] wr_off,
    input  logic [OFF_W-1:0] hr_off,
    input  logic [OFF_W-1:0] ring_mask,
    input  logic [15:0]      byte_k,
    input  logic [17:0]      rec_len,
    output logic [OFF_W-1:0] used,
    output logic             byte_room,
    output logic             rec_room
);

    logic [19:0] ring_w;

    always_comb begin
        used      = (wr_off - hr_off) & ring_mask;
        ring_w    = 20'(ring_mask) + 20'd1;
        // data byte k sits at W+4+k; keep a 4-byte gap to the read side
        byte_room = (20'(used) + 20'(byte_k) + 20'd9) <= ring_w;
        rec_room  = (20'(used) + 20'(rec_len) + 20'd4) <= ring_w;
    end

endmodule

// File: rtl/rxr_byte_ram.sv
module rxr_byte_ram #(
    parameter int DEPTH = 1024,
    parameter int AW    = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
    import rxr_pkg::*;
#(
    parameter int BASE_BYTES = 256,
    parameter int MIN_LEN    = 64,
    parameter int MAX_LEN    = 1522,
    localparam int MAX_RING  = BASE_BYTES * 4,
    localparam int OFF_W     = $clog2(MAX_RING)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       cfg_size_sel,
    input  logic [5:0]       cfg_accept,
    input  logic [47:0]      station_addr,
    input  logic             rx_valid,
    input  logic             rx_sof,
    input  logic             rx_eof,
    input  logic [7:0]       rx_data,
    input  logic             rx_err_align,
    input  logic             rx_err_crc,
    input  logic             rx_err_symbol,
    input  logic             hp_we,
    input  logic [15:0]      hp_wdata,
    input  logic             int_clr_we,
    input  logic [15:0]      int_clr_data,
    output logic [15:0]      int_status,
    output logic             buf_empty,
    input  logic [OFF_W-1:0] host_raddr,
    output logic [7:0]       host_rdata
);

    // ---------------- ring geometry ----------------
    logic [1:0]       sel_eff;
    logic [OFF_W:0]   ring_bytes;
    logic [OFF_W-1:0] ring_mask;

    always_comb begin
        sel_eff    = (cfg_size_sel == 2'd3) ? 2'd2 : cfg_size_sel;
        ring_bytes = (OFF_W+1)'(BASE_BYTES) << sel_eff;
        ring_mask  = ring_bytes[OFF_W-1:0] - OFF_W'(1);
    end

    // ---------------- state ----------------
    wr_state_e        st;
    logic [OFF_W-1:0] wr_off;
    logic [15:0]      hp_q;
    logic [15:0]      cnt_q;
    logic             lost_q;
    logic             pend_q;
    rec_status_t      hdr_stat;
    logic [15:0]      hdr_len;
    logic [17:0]      hdr_rec;
    logic [1:0]       hdr_idx;
    logic             irq_ok, irq_ovf, irq_fifo;

    // ---------------- per-byte decode ----------------
    logic [OFF_W-1:0] hr_off;
    logic [OFF_W-1:0] used_bytes;
    logic [15:0]      k_cnt;
    logic [15:0]      len_now;
    logic             take;
    logic             byte_room, rec_room, lost_now;
    logic [17:0]      rec_now;
    dest_cls_t        cls_next;
    rec_status_t      stat_now;
    logic             pass_addr, pass_err, hard_err;
    logic             keep_now, ovf_now;

    assign hr_off = OFF_W'(hp_q + 16'd16) & ring_mask;
    assign k_cnt  = (st == ST_IDLE) ? 16'd0 : cnt_q;
    assign take   = rx_valid && ((st == ST_IDLE && rx_sof) || st == ST_RECV);
    assign len_now = (&k_cnt) ? k_cnt : k_cnt + 16'd1;
    assign rec_now = rec_span(len_now);

    rxr_dest_filter i_filter (
        .clk      (clk),
        .rst      (rst),
        .take     (take),
        .byte_idx (k_cnt),
        .data     (rx_data),
        .station  (station_addr),
        .cls_next (cls_next)
    );

    rxr_space #(.OFF_W(OFF_W)) i_space (
        .wr_off    (wr_off),
        .hr_off    (hr_off),
        .ring_mask (ring_mask),
        .byte_k    (k_cnt),
        .rec_len   (rec_now),
        .used      (used_bytes),
        .byte_room (byte_room),
        .rec_room  (rec_room)
    );

    always_comb begin
        lost_now          = ((st == ST_RECV) && lost_q) || !byte_room;
        stat_now          = '0;
        stat_now.bcast    = cls_next.bcast;
        stat_now.grp      = cls_next.group && !cls_next.bcast;
        stat_now.phys     = cls_next.own && !cls_next.group;
        stat_now.align    = rx_err_align;
        stat_now.crc      = rx_err_crc;
        stat_now.bad_sym  = rx_err_symbol;
        stat_now.too_long = len_now > 16'(MAX_LEN);
        stat_now.runt     = len_now < 16'(MIN_LEN);
        hard_err          = stat_now.align | stat_now.crc | stat_now.bad_sym | stat_now.too_long;
        stat_now.ok       = !hard_err && !stat_now.runt;

        pass_addr = (cls_next.bcast && cfg_accept[ACC_BCAST])
                 || (cls_next.group && !cls_next.bcast && cfg_accept[ACC_GROUP])
                 || (!cls_next.group && cls_next.own && cfg_accept[ACC_OWN])
                 || (!cls_next.group && cfg_accept[ACC_ALL_UNI]);
        pass_err  = (!hard_err || cfg_accept[ACC_ERR])
                 && (!stat_now.runt || cfg_accept[ACC_RUNT]);

        keep_now  = take && rx_eof && pass_addr && pass_err && rec_room && !lost_now;
        ovf_now   = take && rx_eof && pass_addr && pass_err && !(rec_room && !lost_now);
    end

    // ---------------- memory write port ----------------
    logic             mem_we;
    logic [OFF_W-1:0] mem_waddr;
    logic [7:0]       mem_wdata;

    always_comb begin
        mem_we    = 1'b0;
        mem_waddr = '0;
        mem_wdata = rx_data;
        if (st == ST_HDR) begin
            mem_we    = 1'b1;
            mem_waddr = (wr_off + OFF_W'(hdr_idx)) & ring_mask;
            mem_wdata = hdr_byte(hdr_stat, hdr_len, hdr_idx);
        end else if (take && !lost_now) begin
            mem_we    = 1'b1;
            mem_waddr = (wr_off + OFF_W'(4) + OFF_W'(k_cnt)) & ring_mask;
        end
    end

    rxr_byte_ram #(.DEPTH(MAX_RING), .AW(OFF_W)) i_ram (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (host_raddr),
        .rdata (host_rdata)
    );

    // ---------------- sequencing ----------------
    logic hdr_last;
    assign hdr_last = (st == ST_HDR) && (hdr_idx == 2'd3);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            wr_off   <= '0;
            cnt_q    <= '0;
            lost_q   <= 1'b0;
            pend_q   <= 1'b0;
            hdr_stat <= '0;
            hdr_len  <= '0;
            hdr_rec  <= '0;
            hdr_idx  <= '0;
        end else begin
            case (st)
                ST_IDLE, ST_RECV: begin
                    if (take) begin
                        if (rx_eof) begin
                            hdr_stat <= stat_now;
                            hdr_len  <= len_now;
                            hdr_rec  <= rec_now;
                            hdr_idx  <= 2'd0;
                            pend_q   <= 1'b0;
                            st       <= keep_now ? ST_HDR : ST_IDLE;
                        end else begin
                            cnt_q  <= len_now;
                            lost_q <= lost_now;
                            st     <= ST_RECV;
                        end
                    end
                end
                ST_DROP: begin
                    if (rx_valid && rx_eof) begin
                        st <= ST_IDLE;
                    end
                end
                default: begin
                    hdr_idx <= hdr_idx + 2'd1;
                    if (rx_valid) begin
                        pend_q <= !rx_eof;
                    end
                    if (hdr_last) begin
                        wr_off <= (wr_off + OFF_W'(hdr_rec)) & ring_mask;
                        st     <= ((rx_valid && !rx_eof) || (pend_q && !(rx_valid && rx_eof)))
                                  ? ST_DROP : ST_IDLE;
                    end
                end
            endcase
        end
    end

    // ---------------- host pointer ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            hp_q <= 16'hFFF0;
        end else if (hp_we) begin
            hp_q <= hp_wdata;
        end
    end

    // ---------------- interrupts ----------------
    logic set_ok, set_fifo;
    assign set_ok   = hdr_last && hdr_stat.ok;
    assign set_fifo = (st == ST_HDR) && rx_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_ok   <= 1'b0;
            irq_ovf  <= 1'b0;
            irq_fifo <= 1'b0;
        end else begin
            irq_ok   <= (irq_ok   && !(int_clr_we && int_clr_data[INT_RX_OK]))    || set_ok;
            irq_ovf  <= (irq_ovf  && !(int_clr_we && int_clr_data[INT_RING_OVF])) || ovf_now;
            irq_fifo <= (irq_fifo && !(int_clr_we && int_clr_data[INT_FIFO_OVF])) || set_fifo;
        end
    end

    assign int_status = {9'd0, irq_fifo, 1'b0, irq_ovf, 3'd0, irq_ok};
    assign buf_empty  = (hr_off == wr_off);

endmodule

module rxr_checker #(
    parameter int OFF_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             rx_valid,
    input logic             hp_we,
    input logic             int_clr_we,
    input logic [15:0]      int_clr_data,
    input logic [15:0]      int_status,
    input logic             buf_empty,
    input logic [OFF_W-1:0] wr_off,
    input logic [OFF_W-1:0] ring_mask,
    input logic [OFF_W-1:0] used_bytes,
    input logic             mem_we,
    input logic [OFF_W-1:0] mem_waddr
);

    logic [OFF_W:0] wr_dist;
    logic [OFF_W:0] free_span;

    always_comb begin
        wr_dist   = {1'b0, (mem_waddr - wr_off) & ring_mask};
        free_span = {1'b0, ring_mask} - {1'b0, used_bytes} + (OFF_W+1)'(1);
    end

    p_wr_aligned_r4: assert property (@(posedge clk) disable iff (rst)
        wr_off[1:0] == 2'b00);

    p_wr_step_r4: assert property (@(posedge clk) disable iff (rst)
        !$stable(wr_off) |-> (((wr_off - $past(wr_off)) & ring_mask) >= OFF_W'(8)));

    p_write_free_r9: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (wr_dist < free_span));

    p_empty_rise_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(buf_empty) |-> $past(hp_we));

    p_ok_clear_r12: assert property (@(posedge clk) disable iff (rst)
        $fell(int_status[0]) |-> $past(int_clr_we && int_clr_data[0]));

    p_ovf_clear_r12: assert property (@(posedge clk) disable iff (rst)
        $fell(int_status[4]) |-> $past(int_clr_we && int_clr_data[4]));

    p_fifo_clear_r12: assert property (@(posedge clk) disable iff (rst)
        $fell(int_status[6]) |-> $past(int_clr_we && int_clr_data[6]));

    p_fifo_cause_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(int_status[6]) |-> $past(rx_valid));

endmodule

bind rx_ring_writer rxr_checker #(.OFF_W(OFF_W)) i_chk (
    .clk          (clk),
    .rst          (rst),
    .rx_valid     (rx_valid),
    .hp_we        (hp_we),
    .int_clr_we   (int_clr_we),
    .int_clr_data (int_clr_data),
    .int_status   (int_status),
    .buf_empty    (buf_empty),
    .wr_off       (wr_off),
    .ring_mask    (ring_mask),
    .used_bytes   (used_bytes),
    .mem_we       (mem_we),
    .mem_waddr    (mem_waddr)
);

// File: tb/test_rx_ring_writer.sv
module test_rx_ring_writer;

    localparam int BASE = 256;
    localparam int OW   = $clog2(BASE * 4);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    cfg_size_sel = 2'd0;
    logic [5:0]    cfg_accept = 6'd0;
    logic [47:0]   station_addr = 48'h02_11_22_33_44_55;
    logic          rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
    logic [7:0]    rx_data = 8'd0;
    logic          rx_err_align = 1'b0, rx_err_crc = 1'b0, rx_err_symbol = 1'b0;
    logic          hp_we = 1'b0;
    logic [15:0]   hp_wdata = 16'd0;
    logic          int_clr_we = 1'b0;
    logic [15:0]   int_clr_data = 16'd0;
    logic [15:0]   int_status;
    logic          buf_empty;
    logic [OW-1:0] host_raddr = '0;
    logic [7:0]    host_rdata;

    int checks = 0;
    int failures = 0;
    int exp_wr = 0;
    int ring = BASE;
    bit reported = 1'b0;

    always #10 clk = ~clk;

    rx_ring_writer #(.BASE_BYTES(BASE), .MIN_LEN(64), .MAX_LEN(128)) i_rx_ring_writer (.*);

    // kind, length, accept flags, errors {symbol,crc,align}, kept, status
    typedef struct packed {
        logic [1:0]  kind;
        logic [15:0] len;
        logic [5:0]  acc;
        logic [2:0]  err;
        logic        keep;
        logic [15:0] stat;
    } vec_t;

    localparam vec_t TBL [12] = '{
        '{2'd0, 16'd64,  6'b000010, 3'b000, 1'b1, 16'h4001}, // R7 own
        '{2'd1, 16'd64,  6'b000010, 3'b000, 1'b0, 16'h0000}, // R7 other dropped
        '{2'd1, 16'd70,  6'b000001, 3'b000, 1'b1, 16'h0001}, // R7 all unicast
        '{2'd2, 16'd64,  6'b001000, 3'b000, 1'b1, 16'h2001}, // R7 broadcast
        '{2'd2, 16'd64,  6'b000100, 3'b000, 1'b0, 16'h0000}, // R7 bcast not admitted
        '{2'd3, 16'd66,  6'b000100, 3'b000, 1'b1, 16'h8001}, // R7 group, wraps R13
        '{2'd0, 16'd40,  6'b000010, 3'b000, 1'b0, 16'h0000}, // R8 runt dropped
        '{2'd0, 16'd40,  6'b010010, 3'b000, 1'b1, 16'h4010}, // R8 runt kept
        '{2'd0, 16'd64,  6'b000010, 3'b010, 1'b0, 16'h0000}, // R8 crc dropped
        '{2'd0, 16'd64,  6'b100010, 3'b010, 1'b1, 16'h4004}, // R8 crc kept
        '{2'd0, 16'd130, 6'b100010, 3'b000, 1'b1, 16'h4008}, // R8 too long kept
        '{2'd0, 16'd65,  6'b100010, 3'b101, 1'b1, 16'h4022}  // R3 align+symbol
    };

    function automatic logic [7:0] fbyte(input logic [1:0] kind, input int len, input int i);
        logic [47:0] d;
        case (kind)
            2'd0:    d = 48'h02_11_22_33_44_55;
            2'd1:    d = 48'h02_11_22_33_44_56;
            2'd2:    d = 48'hFF_FF_FF_FF_FF_FF;
            default: d = 48'h01_00_5E_00_00_01;
        endcase
        if (i < 6) return d[(5 - i) * 8 +: 8];
        return 8'((i * 3 + len) & 255);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
            rx_err_align = 1'b0; rx_err_crc = 1'b0; rx_err_symbol = 1'b0;
        end
    endtask

    task automatic send_frame(input logic [1:0] kind, input int len, input logic [2:0] err);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_sof   = (i == 0);
            rx_eof   = (i == len - 1);
            rx_data  = fbyte(kind, len, i);
            rx_err_align  = (i == len - 1) && err[0];
            rx_err_crc    = (i == len - 1) && err[1];
            rx_err_symbol = (i == len - 1) && err[2];
        end
        idle(1);
    endtask

    task automatic read_ram(input int addr, output int val);
        @(negedge clk);
        host_raddr = OW'(addr % ring);
        @(negedge clk);
        val = int'(host_rdata);
    endtask

    task automatic set_hp(input int off);
        @(negedge clk);
        hp_we = 1'b1;
        hp_wdata = 16'(off - 16);
        @(negedge clk);
        hp_we = 1'b0;
    endtask

    task automatic clr_int(input logic [15:0] m);
        @(negedge clk);
        int_clr_we = 1'b1;
        int_clr_data = m;
        @(negedge clk);
        int_clr_we = 1'b0;
    endtask

    function automatic int rec_sz(input int len);
        return (len + 7) & ~3;
    endfunction

    task automatic finish_run();
        if (!reported) begin
            reported = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state: R5 R6 R12
        chk("R6 empty after reset", int'(buf_empty), 1);
        chk("R12 interrupts after reset", int'(int_status), 0);

        // table walk
        for (int e = 0; e < 12; e++) begin
            cfg_accept = TBL[e].acc;
            send_frame(TBL[e].kind, int'(TBL[e].len), TBL[e].err);
            idle(6);
            if (TBL[e].keep) begin
                chk("R6 record visible", int'(buf_empty), 0);
                read_ram(exp_wr + 0, v); chk("R2 R3 status low", v, int'(TBL[e].stat[7:0]));
                read_ram(exp_wr + 1, v); chk("R2 R3 status high", v, int'(TBL[e].stat[15:8]));
                read_ram(exp_wr + 2, v); chk("R2 length low", v, int'(TBL[e].len[7:0]));
                read_ram(exp_wr + 3, v); chk("R2 length high", v, int'(TBL[e].len[15:8]));
                read_ram(exp_wr + 4, v); chk("R2 R14 first byte", v, int'(fbyte(TBL[e].kind, int'(TBL[e].len), 0)));
                read_ram(exp_wr + 3 + int'(TBL[e].len), v);
                chk("R13 last byte", v, int'(fbyte(TBL[e].kind, int'(TBL[e].len), int'(TBL[e].len) - 1)));
                chk("R10 rx ok bit", int'(int_status[0]), int'(TBL[e].stat[0]));
                exp_wr = (exp_wr + rec_sz(int'(TBL[e].len))) % ring;
                clr_int(16'hFFFF);
                set_hp(exp_wr);
                chk("R4 R5 pointer caught up", int'(buf_empty), 1);
            end else begin
                chk("R7 R8 dropped leaves empty", int'(buf_empty), 1);
                chk("R7 R8 dropped no interrupt", int'(int_status), 0);
            end
        end

        // R9: fill ring of 256 until a record no longer fits
        cfg_accept = 6'b000010;
        for (int f = 0; f < 4; f++) begin
            send_frame(2'd0, 64, 3'b000);
            idle(6);
        end
        chk("R9 overflow bit", int'(int_status[4]), 1);
        clr_int(16'h0010);
        chk("R12 overflow bit cleared", int'(int_status[4]), 0);
        chk("R12 rx ok bit kept", int'(int_status[0]), 1);
        exp_wr = (exp_wr + 3 * 68) % ring;
        set_hp(exp_wr);
        chk("R9 dropped record not stored", int'(buf_empty), 1);
        clr_int(16'hFFFF);

        // R1: double ring size, four records now fit
        cfg_size_sel = 2'd1;
        ring = 2 * BASE;
        for (int f = 0; f < 4; f++) begin
            send_frame(2'd0, 64, 3'b000);
            idle(6);
        end
        chk("R1 no overflow at double size", int'(int_status[4]), 0);
        read_ram(exp_wr + 3 * 68 + 2, v);
        chk("R1 fourth record length", v, 64);
        exp_wr = (exp_wr + 4 * 68) % ring;
        set_hp(exp_wr);
        chk("R1 pointer caught up", int'(buf_empty), 1);
        clr_int(16'hFFFF);

        // R11: second frame starts while the first header is written
        send_frame(2'd0, 64, 3'b000);
        send_frame(2'd0, 64, 3'b000);
        idle(6);
        chk("R11 fifo overflow bit", int'(int_status[6]), 1);
        chk("R11 first frame ok bit", int'(int_status[0]), 1);
        exp_wr = (exp_wr + 68) % ring;
        set_hp(exp_wr);
        chk("R11 second frame discarded", int'(buf_empty), 1);
        clr_int(16'h0040);
        chk("R12 fifo bit cleared", int'(int_status[6]), 0);
        send_frame(2'd0, 64, 3'b000);
        idle(6);
        chk("R11 next frame kept", int'(buf_empty), 0);
        read_ram(exp_wr + 2, v);
        chk("R11 next frame length", v, 64);

        finish_run();
    end

endmodule